// File: doc/BRIEF.md
# Daisy-Chain Converter Read and Configure Sequencer

This block is the host side of a serial link to a chain of N converters. All the converters share one chip-select and one serial clock. The host data output feeds the first converter. The last converter's data output returns to the host. A single start pulse runs one complete round of frames:

1. A full conversion frame, which makes every converter sample at the same moment.
2. A short frame that switches the chain into pass-through mode.
3. N full read frames, which carry the results out of the chain one word at a time.
4. A short frame that returns the chain to conversion mode.

During the read frames and the exit frame, the sequencer sends the channel choice for the next round. It sends these words in reverse device order. The first word is a throw-away word that is lost. Every word keeps the mode-hold bit at the inverse of the channel bit, so the converters stay in pass-through mode until the exit frame. The first device's channel goes out in the short exit frame.

The serial clock comes from the system clock through a divider. Each result is placed in the slot of the device that produced it. A result is marked bad when its leading bits are not zero. A one-cycle done pulse closes the round.

Top module: `dcs_chain_seq`

## Requirements
- R1: After reset, `cs_n` and `sclk` are high, `busy` and `done` are low, and every result slot and bad flag is zero.
- R2: A start pulse accepted while idle produces exactly N_DEV+3 frames, in this order: one full frame, the entry short frame, N_DEV full read frames, and the exit short frame. Each full frame has WORD_W (16) falling `sclk` edges.
- R3: In the entry short frame, `cs_n` rises at the time the 12th falling edge would occur. The frame therefore contains 11 complete `sclk` periods.
- R4: In the exit short frame, `cs_n` rises at the time the 13th falling edge would occur. The frame therefore contains 12 complete `sclk` periods.
- R5: `din` changes only on a falling `sclk` edge, and bit 15 of each word goes out first. `dout` is sampled on the rising edge. The conversion frame and the entry frame send all zeros.
- R6: The first read frame sends the throw-away word: bit 15 = 0, bit 14 = 1, and all other bits 0.
- R7: Read frame k (k = 1 .. N_DEV-1, counting from 0) sends the command for device N_DEV-k, with devices numbered 0 nearest the host. In a command word, bit 15 is that device's `chan_sel` bit, bit 14 is its inverse, and all other bits are 0.
- R8: The exit short frame sends the command word of device 0. Only its first 12 bits go out.
- R9: The word received in read frame k is stored in result slot N_DEV-1-k. Bits 13..4 of the received word become the 10-bit result, at `results[slot*10 +: 10]`.
- R10: `bad[slot]` is set when bits 15..14 of that slot's received word are not both zero, and is cleared otherwise.
- R11: `sclk` stays high whenever `cs_n` is high. `cs_n` stays high for at least CS_GAP (2) system clocks before each frame starts. Each `sclk` half period lasts SCLK_DIV (2) system clocks.
- R12: `done` pulses for one cycle after the exit frame, in the cycle where `busy` falls. A start pulse while `busy` is high has no effect on the round in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts one round when idle |
| chan_sel | input | N_DEV | Channel choice per device for the next round, bit 0 for device 0 |
| dout | input | 1 | Serial data from the last device in the chain |
| cs_n | output | 1 | Shared chip-select, active low |
| sclk | output | 1 | Shared serial clock, idle high |
| din | output | 1 | Serial data to the first device in the chain |
| busy | output | 1 | High while a round is running |
| done | output | 1 | One-cycle pulse when the round ends |
| results | output | N_DEV*RES_W | Result slots, slot g at [g*RES_W +: RES_W] |
| bad | output | N_DEV | Per-slot flag for leading bits that are not zero |

## Verification
The assertions assume a few things about the block's inputs:
- `dout` changes only while `sclk` is low. This is the behaviour of a chain that updates its output on the falling edge.
- `chan_sel` holds steady for the whole round.
- `start` is a one-cycle pulse.

The bench meets these conditions with a behavioural model of the converter chain. The model updates each device's output a half system clock after the falling edge it detects. `chan_sel` and the device data change only between rounds. A second start pulse is placed deliberately in the middle of one round, and nowhere else.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GAP   = 2'd1,
      ST_FRAME = 2'd2
   } dcs_state_e;

   // Leading two bits of a chain command: channel, then hold bit as its inverse
   function automatic logic [1:0] dcs_cmd(input logic ch);
      return {ch, ~ch};
   endfunction

endpackage

// File: rtl/dcs_tick.sv
module dcs_tick #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad
         $error("dcs_tick: DIV must be at least 1");
      end

      if (DIV <= 1) begin : g_every
         assign tick = !clr;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clr || cnt == CW'(DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = !clr && (cnt == CW'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/dcs_shifter.sv
module dcs_shifter #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned KEEP_W = 12,
   parameter int unsigned CYC_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              go,
   input  logic [WORD_W-1:0] word,
   input  logic [CYC_W-1:0]  ncyc,
   input  logic              rx_bit,
   output logic              cs_n,
   output logic              sclk,
   output logic              din,
   output logic [KEEP_W-1:0] rx_keep,
   output logic              fdone
);

   localparam int unsigned HC_W = CYC_W + 1;

   generate
      if (KEEP_W > WORD_W || KEEP_W < 1) begin : g_chk
         $error("dcs_shifter: KEEP_W out of range");
      end
   endgenerate

   logic              running;
   logic [HC_W-1:0]   hc;
   logic [WORD_W-1:0] txsh;
   logic [WORD_W-1:0] rxsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cs_n    <= 1'b1;
         sclk    <= 1'b1;
         din     <= 1'b0;
         hc      <= '0;
         txsh    <= '0;
         rxsh    <= '0;
         fdone   <= 1'b0;
      end else begin
         fdone <= 1'b0;
         if (!running) begin
            if (go) begin
               running <= 1'b1;
               cs_n    <= 1'b0;
               txsh    <= word;
               hc      <= '0;
            end
         end else if (tick) begin
            if (hc == {ncyc, 1'b0}) begin
               running <= 1'b0;
               cs_n    <= 1'b1;
               fdone   <= 1'b1;
            end else if (!hc[0]) begin
               sclk <= 1'b0;
               din  <= txsh[WORD_W-1];
               txsh <= {txsh[WORD_W-2:0], 1'b0};
               hc   <= hc + 1'b1;
            end else begin
               sclk <= 1'b1;
               rxsh <= {rxsh[WORD_W-2:0], rx_bit};
               hc   <= hc + 1'b1;
            end
         end
      end
   end

   assign rx_keep = rxsh[WORD_W-1 -: KEEP_W];

endmodule

// File: rtl/dcs_chain_seq.sv
module dcs_chain_seq
   import dcs_pkg::*;
#(
   parameter int unsigned N_DEV      = 2,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned RES_W      = 10,
   parameter int unsigned LEAD_W     = 2,
   parameter int unsigned SCLK_DIV   = 2,
   parameter int unsigned CS_GAP     = 2,
   parameter int unsigned ENTRY_EDGE = 12,
   parameter int unsigned EXIT_EDGE  = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [N_DEV-1:0]       chan_sel,
   input  logic                   dout,
   output logic                   cs_n,
   output logic                   sclk,
   output logic                   din,
   output logic                   busy,
   output logic                   done,
   output logic [N_DEV*RES_W-1:0] results,
   output logic [N_DEV-1:0]       bad
);

   localparam int unsigned N_FRAMES = N_DEV + 3;
   localparam int unsigned LAST     = N_DEV + 2;
   localparam int unsigned FI_W     = $clog2(N_FRAMES);
   localparam int unsigned CYC_W    = $clog2(WORD_W + 1);
   localparam int unsigned GAP_W    = $clog2(CS_GAP + 1);
   localparam int unsigned KEEP_W   = LEAD_W + RES_W;

   generate
      if (N_DEV < 1) begin : g_e0
         $error("dcs_chain_seq: need at least one device");
      end
      if (ENTRY_EDGE < 11 || ENTRY_EDGE > 12) begin : g_e1
         $error("dcs_chain_seq: ENTRY_EDGE must be 11 or 12");
      end
      if (EXIT_EDGE < 11 || EXIT_EDGE > 13) begin : g_e2
         $error("dcs_chain_seq: EXIT_EDGE must be 11 to 13");
      end
      if (KEEP_W > WORD_W || WORD_W < EXIT_EDGE) begin : g_e3
         $error("dcs_chain_seq: word too narrow");
      end
      if (CS_GAP < 1) begin : g_e4
         $error("dcs_chain_seq: CS_GAP must be at least 1");
      end
   endgenerate

   dcs_state_e        state;
   logic [FI_W-1:0]   fidx;
   logic [GAP_W-1:0]  gcnt;
   logic              go;
   logic              tick;
   logic              fdone;
   logic              chbit;
   logic [WORD_W-1:0] fword;
   logic [CYC_W-1:0]  ncyc;
   logic [KEEP_W-1:0] rx_keep;

   // Frame contents chosen by frame index
   always_comb begin
      chbit = 1'b0;
      for (int d = 0; d < int'(N_DEV); d++) begin
         if (fidx == FI_W'(N_DEV + 2 - d)) chbit = chan_sel[d];
      end
      fword = '0;
      if (fidx >= FI_W'(2)) fword[WORD_W-1 -: 2] = dcs_cmd(chbit);
      ncyc = CYC_W'(WORD_W);
      if (fidx == FI_W'(1))    ncyc = CYC_W'(ENTRY_EDGE - 1);
      if (fidx == FI_W'(LAST)) ncyc = CYC_W'(EXIT_EDGE - 1);
   end

   assign go = (state == ST_GAP) && (gcnt == GAP_W'(CS_GAP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         fidx  <= '0;
         gcnt  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_GAP;
                  fidx  <= '0;
                  gcnt  <= '0;
               end
            end
            ST_GAP: begin
               if (go) state <= ST_FRAME;
               else    gcnt  <= gcnt + 1'b1;
            end
            ST_FRAME: begin
               if (fdone) begin
                  if (fidx == FI_W'(LAST)) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     fidx  <= fidx + 1'b1;
                     gcnt  <= '0;
                     state <= ST_GAP;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

   dcs_tick #(.DIV(SCLK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go),
      .tick  (tick)
   );

   dcs_shifter #(.WORD_W(WORD_W), .KEEP_W(KEEP_W), .CYC_W(CYC_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .go      (go),
      .word    (fword),
      .ncyc    (ncyc),
      .rx_bit  (dout),
      .cs_n    (cs_n),
      .sclk    (sclk),
      .din     (din),
      .rx_keep (rx_keep),
      .fdone   (fdone)
   );

   // Result slots: device g answers in frame N_DEV+1-g
   generate
      for (genvar g = 0; g < int'(N_DEV); g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               results[g*RES_W +: RES_W] <= '0;
               bad[g]                    <= 1'b0;
            end else if (state == ST_FRAME && fdone && fidx == FI_W'(N_DEV + 1 - g)) begin
               results[g*RES_W +: RES_W] <= rx_keep[RES_W-1:0];
               bad[g]                    <= |rx_keep[KEEP_W-1 -: LEAD_W];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dcs_chain_chk.sv
module dcs_chain_chk #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned CS_GAP     = 2,
   parameter int unsigned ENTRY_EDGE = 12,
   parameter int unsigned EXIT_EDGE  = 13
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic din,
   input logic busy,
   input logic done
);

   logic       sclk_q;
   logic [7:0] fall_cnt;
   logic [7:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b1;
         fall_cnt <= '0;
         hi_cnt   <= 8'(CS_GAP);
      end else begin
         sclk_q <= sclk;
         if (cs_n) fall_cnt <= '0;
         else if (sclk_q && !sclk) fall_cnt <= fall_cnt + 1'b1;
         if (!cs_n) hi_cnt <= '0;
         else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk); // R11

   AST_CS_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= 8'(CS_GAP))); // R11

   AST_DIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(sclk) |-> $stable(din)); // R5

   AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (fall_cnt == 8'(WORD_W) || fall_cnt == 8'(ENTRY_EDGE - 1)
                       || fall_cnt == 8'(EXIT_EDGE - 1))); // R2

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R12

   AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy); // R2

endmodule

bind dcs_chain_seq dcs_chain_chk #(
   .WORD_W     (WORD_W),
   .CS_GAP     (CS_GAP),
   .ENTRY_EDGE (ENTRY_EDGE),
   .EXIT_EDGE  (EXIT_EDGE)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (cs_n),
   .sclk  (sclk),
   .din   (din),
   .busy  (busy),
   .done  (done)
);

// File: tb/dcs_chain_seq_test.sv
module dcs_chain_seq_test;

   localparam int N  = 2;
   localparam int W  = 16;
   localparam int RW = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [N-1:0]  chan_sel = '0;
   logic          dout;
   logic          cs_n, sclk, din, busy, done;
   logic [N*RW-1:0] results;
   logic [N-1:0]  bad;

   dcs_chain_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel), .dout(dout),
      .cs_n(cs_n), .sclk(sclk), .din(din), .busy(busy), .done(done),
      .results(results), .bad(bad)
   );

   int vec = 0;
   int miss = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vec++;
      if (!ok) begin
         miss++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Behavioural chain of converters
   logic [W-1:0]  sreg [N];
   logic          dev_out [N];
   logic [RW-1:0] dev_data [N];
   logic [1:0]    dev_lead [N];
   int            fr = 0;
   int            nfall = 0;
   int            gap_hi = 100;
   int            done_seen = 0;
   logic [W-1:0]  cap = '0;
   logic          p_cs = 1'b1;
   logic          p_sclk = 1'b1;

   initial begin
      for (int k = 0; k < N; k++) begin
         sreg[k] = '0; dev_out[k] = 1'b0; dev_data[k] = '0; dev_lead[k] = '0;
      end
   end

   assign dout = dev_out[N-1];

   function automatic int exp_len(input int f);
      if (f == 1)     return 11;   // R3
      if (f == N + 2) return 12;   // R4
      return W;
   endfunction

   function automatic logic [W-1:0] exp_word(input int f);
      logic c;
      int   idx;
      logic [W-1:0] w;
      if (f < 2) return '0;
      idx = N + 2 - f;
      c = (idx == N) ? 1'b0 : chan_sel[idx];
      w = '0;
      w[W-1] = c;
      w[W-2] = ~c;
      return w >> (W - exp_len(f));
   endfunction

   function automatic string word_req(input int f);
      if (f < 2)      return "R5";
      if (f == 2)     return "R6";
      if (f == N + 2) return "R8";
      return "R7";
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_n) chk(sclk === 1'b1, "R11", "sclk level while cs_n high", sclk, 1);
         if (p_cs && !cs_n) begin
            chk(gap_hi >= 2, "R11", "cs_n high cycles before frame", gap_hi, 2);
            nfall = 0;
            cap = '0;
            if (fr == 0) begin
               for (int k = 0; k < N; k++) begin
                  sreg[k] = {dev_lead[k], dev_data[k], 4'b0000};
                  dev_out[k] = sreg[k][W-1];
               end
            end else if (fr >= 2 && fr <= N + 1) begin
               for (int k = 0; k < N; k++) dev_out[k] = sreg[k][W-1];
            end
         end else if (!cs_n && p_sclk && !sclk) begin
            nfall++;
            if (fr >= 2 && fr <= N + 1)
               for (int k = 0; k < N; k++) dev_out[k] = sreg[k][W-1];
         end else if (!cs_n && !p_sclk && sclk) begin
            cap = {cap[W-2:0], din};
            if (fr >= 2 && fr <= N + 1)
               for (int k = N - 1; k >= 0; k--)
                  sreg[k] = {sreg[k][W-2:0], (k == 0) ? din : dev_out[k-1]};
         end
         if (!p_cs && cs_n) begin
            chk(nfall == exp_len(fr), (fr == 1) ? "R3" : (fr == N + 2) ? "R4" : "R2",
                $sformatf("falling edges in frame %0d", fr), nfall, exp_len(fr));
            chk(cap == exp_word(fr), word_req(fr),
                $sformatf("din word in frame %0d", fr), cap, exp_word(fr));
            fr++;
         end
         gap_hi = cs_n ? gap_hi + 1 : 0;
         if (done) done_seen++;
      end
      p_cs = cs_n;
      p_sclk = sclk;
   end

   task automatic run_round(input logic [N-1:0] ch,
                            input logic [RW-1:0] d0, input logic [RW-1:0] d1,
                            input logic [1:0] l0, input logic [1:0] l1,
                            input bit poke);
      int t;
      chan_sel = ch;
      dev_data[0] = d0; dev_data[1] = d1;
      dev_lead[0] = l0; dev_lead[1] = l1;
      fr = 0;
      done_seen = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy === 1'b1, "R12", "busy after start", busy, 1);
      if (poke) begin
         repeat (100) @(negedge clk);
         start = 1'b1;          // R12: must be ignored
         @(negedge clk) start = 1'b0;
      end
      t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!done && t < 20000);
      if (t >= 20000) chk(1'b0, "R12", "done never seen", 0, 1);
      chk(busy === 1'b0, "R12", "busy in done cycle", busy, 0);
      @(negedge clk);
      chk(done === 1'b0, "R12", "done width", done, 0);
      repeat (3) @(negedge clk);
      chk(done_seen == 1, "R12", "done pulses per round", done_seen, 1);
      chk(fr == N + 3, "R2", "frames per round", fr, N + 3);
      chk(cs_n === 1'b1, "R12", "no frame after round", cs_n, 1);
      for (int k = 0; k < N; k++) begin
         chk(results[k*RW +: RW] == dev_data[k], "R9", $sformatf("result slot %0d", k),
             results[k*RW +: RW], dev_data[k]);
         chk(bad[k] == |dev_lead[k], "R10", $sformatf("bad flag slot %0d", k),
             bad[k], |dev_lead[k]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n === 1'b1, "R1", "cs_n in reset", cs_n, 1);
      chk(sclk === 1'b1, "R1", "sclk in reset", sclk, 1);
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
      chk(results == '0 && bad == '0, "R1", "slots in reset", results, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      run_round(2'b01, 10'h2A5, 10'h15A, 2'b00, 2'b00, 1'b0);
      run_round(2'b10, 10'h3FF, 10'h001, 2'b00, 2'b01, 1'b1);
      run_round(2'b11, 10'h000, 10'h200, 2'b10, 2'b00, 1'b0);
      run_round(2'b00, 10'h133, 10'h0CC, 2'b11, 2'b11, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end

   initial begin
      #(200000 * 8);
      vec++;
      miss++;
      $display("FAIL WATCHDOG: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end

endmodule